// File: doc/BRIEF.md
# Two-Wire Target Port Expander

This block is a two-wire serial (I2C) target that owns one 8-bit quasi-bidirectional port. It oversamples the open-drain clock and data lines with its own system clock and finds start and stop conditions from them. It matches a 7-bit address whose upper four bits are fixed and whose lower three bits come from strap pins. A write transaction loads an output latch that drives the port. A read transaction samples the port pins and shifts them back to the controller. The block pulls the data line low to acknowledge and to send zero bits. It never stretches the clock.

An active-low interrupt line tells the controller that the port inputs have moved away from the value captured at the last port access. Any read or write that reaches the port clears it. After reset the output latch is all ones, so every pin is weakly high and can be used as an input.

Top module: `i2cx_expander`

## Requirements
- R1: After reset, `portOut` is 0xFF, `intN` is 1 and `sdaPullDn` is 0.
- R2: The target acknowledges (pulls SDA low during the ninth clock) an address byte whose seven upper bits equal binary 0100 followed by `strap[2]`, `strap[1]`, `strap[0]`. Any other address gets no acknowledge, and the data bytes that follow leave `portOut` unchanged.
- R3: The last bit of the address byte selects the direction: 0 is a write and 1 is a read. Write data arrives most significant bit first. Each byte is acknowledged, and it lands on `portOut` at the rising clock edge of its acknowledge bit. Every later byte in the same transaction replaces the port value again.
- R4: A stop condition (SDA rising while SCL is high) in the middle of a write byte drops that partial byte. `portOut` keeps the value of the last acknowledged byte.
- R5: In a read, the port is sampled at the start of each byte and shifted out most significant bit first. A controller acknowledge asks for another byte, and that byte is a fresh sample of the port.
- R6: After a controller not-acknowledge on a read byte, the target releases SDA and ignores further clocks until a start or stop.
- R7: `intN` goes low when the synchronized port input differs from the value captured at the last port access, meaning a read-byte sample or a write commit. `intN` is high in the cycle after any such access.
- R8: A start condition (SDA falling while SCL is high) with no stop before it, even in the middle of a byte, restarts address reception. Any partial write byte is dropped.
- R9: The matched address follows the strap pins. After the straps change, the old address is no longer acknowledged.
- R10: The target changes `sdaPullDn` only while the synchronized SCL is low, and it has released SDA in the cycle after a detected stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| sdaPullDn | output | 1 | 1 pulls the data line low |
| strap | input | 3 | Low three address bits |
| portIn | input | 8 | Port pin levels |
| portOut | output | 8 | Port output latch |
| intN | output | 1 | Active-low input-change interrupt |

## Verification
The assertions check on every cycle that the data line moves only while SCL is low and is released after a stop. They also check that the port latch changes only on a commit strobe, that the control strobes never overlap, that a read load puts the sampled most significant bit on the line, and that any port access leaves the interrupt high. Some behaviours appear only in the bench scenarios: address matching against the straps, byte values arriving most significant bit first, the per-byte resampling of a changing port, dropping a partial byte on a stop or repeated start, and the target staying silent after a controller not-acknowledge. The bench's reference model follows the expected port latch and interrupt line between transactions.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_WAIT
  } busState_t;

  // strobes from control to datapath, one cycle wide
  typedef struct packed {
    logic sampleBit;  // shift one received bit in
    logic loadTx;     // sample port into transmit register
    logic shiftTx;    // advance transmit register
    logic commitOut;  // copy received byte to port latch
  } strobe_t;
endpackage

// File: rtl/i2cx_sync.sv
module i2cx_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] r;
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) r <= RST_VAL;
        else r <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) r <= RST_VAL;
        else r <= g_stage[s-1].r;
    end
  end
  assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/i2cx_ctrl.sv
module i2cx_ctrl
  import i2cx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclIn,
  input  logic    sdaIn,
  input  logic    addrHit,
  input  logic    rwBit,
  output strobe_t strb,
  output logic    ackDrive,
  output logic    txActive,
  output logic    sclSync,
  output logic    sdaSync,
  output logic    stopEv
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  busState_t state;
  logic [CNT_W-1:0] bitCnt;
  logic sclPrev, sdaPrev, masterAck;
  logic sclRise, sclFall, startEv, byteDone;

  i2cx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) busSync_i (
    .clk(clk), .rstN(rstN), .d({sclIn, sdaIn}), .q({sclSync, sdaSync})
  );

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclSync;
      sdaPrev <= sdaSync;
    end

  assign sclRise  = sclSync & ~sclPrev;
  assign sclFall  = ~sclSync & sclPrev;
  assign startEv  = sclSync & sclPrev & sdaPrev & ~sdaSync;
  assign stopEv   = sclSync & sclPrev & ~sdaPrev & sdaSync;
  assign byteDone = (bitCnt == FULL);

  always_comb begin
    strb = '0;
    strb.sampleBit = sclRise && (state == ST_ADDR || state == ST_WR);
    strb.commitOut = sclRise && state == ST_WR_ACK;
    strb.loadTx    = sclFall && ((state == ST_ADDR_ACK && rwBit) ||
                                 (state == ST_RD_ACK && masterAck));
    strb.shiftTx   = sclFall && state == ST_RD && !byteDone;
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      ackDrive  <= 1'b0;
      txActive  <= 1'b0;
      masterAck <= 1'b0;
    end else if (startEv) begin
      state    <= ST_ADDR;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      txActive <= 1'b0;
    end else if (stopEv) begin
      state    <= ST_IDLE;
      ackDrive <= 1'b0;
      txActive <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_WR: begin
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          if (sclFall && byteDone) begin
            if (state == ST_WR) begin
              state    <= ST_WR_ACK;
              ackDrive <= 1'b1;
            end else if (addrHit) begin
              state    <= ST_ADDR_ACK;
              ackDrive <= 1'b1;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        ST_ADDR_ACK, ST_WR_ACK: begin
          if (sclFall) begin
            ackDrive <= 1'b0;
            bitCnt   <= '0;
            if (state == ST_ADDR_ACK && rwBit) begin
              state    <= ST_RD;
              txActive <= 1'b1;
            end else begin
              state <= ST_WR;
            end
          end
        end
        ST_RD: begin
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          if (sclFall && byteDone) begin
            state    <= ST_RD_ACK;
            txActive <= 1'b0;
          end
        end
        ST_RD_ACK: begin
          if (sclRise) masterAck <= ~sdaSync;
          if (sclFall) begin
            bitCnt <= '0;
            if (masterAck) begin
              state    <= ST_RD;
              txActive <= 1'b1;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
endmodule

// File: rtl/i2cx_dpath.sv
module i2cx_dpath
  import i2cx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STRAP_W = 3,
  parameter logic [ADDR_W-STRAP_W-1:0] ADDR_HI = 4'b0100
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic               sdaBit,
  input  logic [STRAP_W-1:0] strap,
  input  logic [BYTE_W-1:0]  portIn,
  output logic               addrHit,
  output logic               rwBit,
  output logic               txMsb,
  output logic [BYTE_W-1:0]  portSync,
  output logic [BYTE_W-1:0]  portOut,
  output logic               intN
);
  logic [BYTE_W-1:0] rxShift, txShift, refVal;
  logic irq, portAccess;

  i2cx_sync #(.WIDTH(BYTE_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) portSync_i (
    .clk(clk), .rstN(rstN), .d(portIn), .q(portSync)
  );

  assign addrHit    = (rxShift[BYTE_W-1:1] == {ADDR_HI, strap});
  assign rwBit      = rxShift[0];
  assign txMsb      = txShift[BYTE_W-1];
  assign portAccess = strb.loadTx | strb.commitOut;
  assign intN       = ~irq;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) rxShift <= '0;
    else if (strb.sampleBit) rxShift <= {rxShift[BYTE_W-2:0], sdaBit};

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) txShift <= '1;
    else if (strb.loadTx) txShift <= portSync;
    else if (strb.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b1};

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) portOut <= '1;
    else if (strb.commitOut) portOut <= rxShift;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      refVal <= '1;
      irq    <= 1'b0;
    end else if (portAccess) begin
      refVal <= portSync;
      irq    <= 1'b0;
    end else begin
      irq <= (portSync != refVal);
    end
endmodule

// File: rtl/i2cx_expander.sv
module i2cx_expander
  import i2cx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STRAP_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sdaPullDn,
  input  logic [STRAP_W-1:0] strap,
  input  logic [BYTE_W-1:0]  portIn,
  output logic [BYTE_W-1:0]  portOut,
  output logic               intN
);
  strobe_t strb;
  logic ackDrive, txActive, sclSync, sdaSync, stopEv;
  logic addrHit, rwBit, txMsb;
  logic [BYTE_W-1:0] portSync;

  i2cx_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrHit(addrHit), .rwBit(rwBit), .strb(strb),
    .ackDrive(ackDrive), .txActive(txActive),
    .sclSync(sclSync), .sdaSync(sdaSync), .stopEv(stopEv)
  );

  i2cx_dpath #(.SYNC_STAGES(SYNC_STAGES), .STRAP_W(STRAP_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaBit(sdaSync),
    .strap(strap), .portIn(portIn), .addrHit(addrHit), .rwBit(rwBit),
    .txMsb(txMsb), .portSync(portSync), .portOut(portOut), .intN(intN)
  );

  assign sdaPullDn = ackDrive | (txActive & ~txMsb);
endmodule

// File: rtl/i2cx_expander_chk.sv
module i2cx_expander_chk
  import i2cx_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input strobe_t           strb,
  input logic              sclSync,
  input logic              stopEv,
  input logic              sdaPullDn,
  input logic [BYTE_W-1:0] portOut,
  input logic [BYTE_W-1:0] portSync,
  input logic              txMsb,
  input logic              intN
);
  assert_sda_moves_scl_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    (sclSync && $past(sclSync)) |-> $stable(sdaPullDn));

  assert_release_after_stop_R10: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> !sdaPullDn);

  assert_port_only_on_commit_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(portOut) |-> $past(strb.commitOut));

  assert_strobes_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

  assert_load_drives_msb_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadTx |=> (txMsb == $past(portSync[BYTE_W-1])));

  assert_access_clears_int_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadTx || strb.commitOut) |=> intN);
endmodule

bind i2cx_expander i2cx_expander_chk chk_i (
  .clk(clk), .rstN(rstN), .strb(strb), .sclSync(sclSync), .stopEv(stopEv),
  .sdaPullDn(sdaPullDn), .portOut(portOut), .portSync(portSync),
  .txMsb(txMsb), .intN(intN)
);

// File: tb/i2cx_expander_tb.sv
`timescale 1ns/1ps
module i2cx_expander_tb_top;
  localparam int Q = 8;
  localparam int WDOG = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic [2:0] strap = 3'b101;
  logic [7:0] portIn = 8'hFF;
  logic [7:0] portOut;
  logic sdaPullDn, intN, busSda;

  int total = 0, bad = 0, cyc = 0, quiet = 0;
  bit hold = 1'b1, ended = 1'b0;
  logic [7:0] expPort = 8'hFF, refModel = 8'hFF;

  always #2.5 clk = ~clk;
  assign busSda = sdaM & ~sdaPullDn;

  i2cx_expander dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(busSda), .sdaPullDn(sdaPullDn),
    .strap(strap), .portIn(portIn), .portOut(portOut), .intN(intN)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // reference model compared on every clock once the bus is quiet
  always begin
    @(posedge clk); #1;
    cyc++;
    if (rstN && !hold) begin
      if (quiet >= 6) begin
        check(portOut == expPort, "R3 model port", portOut, expPort);
        check(intN == (portIn == refModel), "R7 model int", intN, portIn == refModel);
      end else quiet++;
    end
    if (cyc > WDOG) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
      finishRun();
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startC();
    sdaM = 1'b1; tick(Q); sclM = 1'b1; tick(Q); sdaM = 1'b0; tick(Q); sclM = 1'b0; tick(Q);
  endtask

  task automatic stopC();
    sdaM = 1'b0; tick(Q); sclM = 1'b1; tick(Q); sdaM = 1'b1; tick(Q);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; tick(Q); sclM = 1'b1; tick(2 * Q); sclM = 1'b0; tick(Q);
  endtask

  task automatic recvBit(output logic b);
    sdaM = 1'b1; tick(Q); sclM = 1'b1; tick(Q); b = busSda; tick(Q); sclM = 1'b0; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] v, output bit acked);
    logic a;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    recvBit(a);
    acked = !a;
  endtask

  task automatic rd8(output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recvBit(b);
      v[i] = b;
    end
  endtask

  task automatic settle(input logic [7:0] p);
    expPort = p; refModel = portIn; quiet = 0; hold = 1'b0;
    tick(12);
  endtask

  task automatic setPort(input logic [7:0] v);
    portIn = v; quiet = 0; tick(12);
  endtask

  initial begin
    bit ack;
    logic [7:0] rv;
    logic b;
    tick(4);
    check(portOut == 8'hFF, "R1 reset port", portOut, 8'hFF);
    check(intN == 1'b1, "R1 reset int", intN, 1);
    check(sdaPullDn == 1'b0, "R1 reset sda", sdaPullDn, 0);
    rstN = 1'b1; tick(4);
    hold = 1'b0; quiet = 0; tick(10);

    // write two bytes to 0100_101
    hold = 1'b1;
    startC(); sendByte({7'b0100101, 1'b0}, ack);
    check(ack, "R2 address ack", ack, 1);
    sendByte(8'hA5, ack); tick(2);
    check(ack && portOut == 8'hA5, "R3 first byte", portOut, 8'hA5);
    sendByte(8'h3C, ack); tick(2);
    check(ack && portOut == 8'h3C, "R3 second byte", portOut, 8'h3C);
    stopC(); tick(2);
    check(sdaPullDn == 1'b0, "R10 released after stop", sdaPullDn, 0);
    settle(8'h3C);

    // wrong address
    hold = 1'b1;
    startC(); sendByte({7'b0100011, 1'b0}, ack);
    check(!ack, "R2 no ack wrong address", ack, 0);
    sendByte(8'h00, ack); stopC(); tick(6);
    check(portOut == 8'h3C, "R2 port untouched", portOut, 8'h3C);
    settle(8'h3C);

    // stop in the middle of a byte
    hold = 1'b1;
    startC(); sendByte({7'b0100101, 1'b0}, ack); sendByte(8'h81, ack);
    for (int i = 0; i < 4; i++) sendBit(1'b0);
    stopC(); tick(6);
    check(portOut == 8'h81, "R4 partial byte dropped", portOut, 8'h81);
    settle(8'h81);

    // repeated start in the middle of a byte
    hold = 1'b1;
    startC(); sendByte({7'b0100101, 1'b0}, ack);
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b0);
    startC(); tick(4);
    check(portOut == 8'h81, "R8 partial dropped on restart", portOut, 8'h81);
    sendByte({7'b0100101, 1'b0}, ack);
    check(ack, "R8 address after restart", ack, 1);
    sendByte(8'h42, ack); stopC(); tick(4);
    check(portOut == 8'h42, "R8 write after restart", portOut, 8'h42);
    settle(8'h42);

    // interrupt on change, then read two bytes with resampling
    setPort(8'h5A);
    check(intN == 1'b0, "R7 int on change", intN, 0);
    hold = 1'b1;
    startC(); sendByte({7'b0100101, 1'b1}, ack);
    check(ack, "R2 read address ack", ack, 1);
    rd8(rv);
    check(rv == 8'h5A, "R5 first read byte", rv, 8'h5A);
    portIn = 8'hC3; tick(4);
    sendBit(1'b0);
    rd8(rv);
    check(rv == 8'hC3, "R5 resampled byte", rv, 8'hC3);
    sendBit(1'b1);
    recvBit(b);
    check(b == 1'b1, "R6 released after nack", b, 1);
    recvBit(b);
    check(b == 1'b1, "R6 still silent", b, 1);
    stopC(); tick(6);
    check(intN == 1'b1, "R7 cleared by read", intN, 1);
    settle(8'h42);

    setPort(8'h00);
    check(intN == 1'b0, "R7 int second change", intN, 0);
    hold = 1'b1;
    startC(); sendByte({7'b0100101, 1'b0}, ack); sendByte(8'h77, ack);
    stopC(); tick(6);
    check(intN == 1'b1, "R7 cleared by write", intN, 1);
    settle(8'h77);

    // strap change
    strap = 3'b000; tick(4);
    hold = 1'b1;
    startC(); sendByte({7'b0100101, 1'b0}, ack);
    check(!ack, "R9 old address ignored", ack, 0);
    stopC();
    startC(); sendByte({7'b0100000, 1'b0}, ack);
    check(ack, "R9 new address ack", ack, 1);
    sendByte(8'h19, ack); stopC(); tick(4);
    check(portOut == 8'h19, "R9 write at new address", portOut, 8'h19);
    settle(8'h19);

    tick(20);
    finishRun();
  end
endmodule